// File: doc/BRIEF.md
# Key-Guarded Independent Watchdog

A watchdog timer controlled through a 16-bit register port in the bus clock domain, with its down-counter running on a separate slow clock. Software never writes a control bit directly. It writes magic values to a key register. One value opens the configuration registers for writing and another closes them. A third value feeds the watchdog by reloading the counter, and a fourth starts it. Once started, software cannot stop the watchdog.

The divider code and the 12-bit reload value set the timeout. Every configuration write, and every feed, is moved into the slow domain by a single toggle request/acknowledge channel with two-flop synchronisers on each side. Each register's pending flag in the status word stays set until the slow side has taken the new value. A register whose flag is still set refuses further writes. When the counter is already at zero and a prescaled tick arrives, the block raises `wdog_rst_req` for one slow-clock cycle and reloads the counter.

The register port is plain: a write happens on any bus clock edge with `wr_en` high, and `rdata` combinationally reflects `addr`. The port has no valid/ready stream, so it has no back-pressure. Software must poll the pending flags before it rewrites a register.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the registers read as follows: divider code (0x004) reads 0, reload (0x008) reads 0xFFF, status (0x00C) reads 0, early-wake control (0x014) reads 0, and bits [7:0] of the revision register (0x3F4) read 0x31. `wdog_rst_req` is low.
- R2: The key register sits at 0x000 and uses wdata[15:0]. Writing key 0x5555 opens the divider, reload and early-wake registers for writing, and key 0x0000 closes them again. A write to any of these registers while they are closed leaves its read-back value unchanged.
- R3: A key value other than 0x5555, 0x0000, 0xAAAA or 0xCCCC leaves the open/closed state unchanged.
- R4: In the status word, bit 0 (divider), bit 1 (reload) and bit 3 (early-wake) read 1 from the cycle after an accepted write to that register until the slow domain has taken the value, and then read 0. Bit 2 always reads 0.
- R5: A write to a register whose pending bit is set is ignored, and the earlier value is the one that is kept.
- R6: Key 0xCCCC starts the watchdog. Status bit 8 then reads 1 within 20 bus cycles and never returns to 0. Writing key 0x0000 after the start does not stop the expiry pulses.
- R7: While the watchdog runs without feeds, consecutive `wdog_rst_req` pulses are (reload+1)·2^(code+2) slow cycles apart. Each pulse is exactly one slow cycle wide.
- R8: Key 0xAAAA reloads the counter from the reload value whether the registers are open or closed. Feeding the watchdog more often than the timeout keeps `wdog_rst_req` low.
- R9: `wdog_rst_req` stays low until the watchdog has been started.
- R10: In the early-wake control register, bit 15 (interrupt enable) and bits [11:0] (compare value) are stored and read back. Bit 14 is a write-one acknowledge, so it is not stored and always reads 0.
- R11: Divider codes of 6 and above all select a division of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| slow_clk | input | 1 | Slow counting clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| wdog_rst_req | output | 1 | Reset request, one slow cycle wide, in the slow domain |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a 4-bit divider code and an 8-bit prescaler that saturates at 256. Programming small reload values keeps the expiry intervals between 4 and a few hundred slow cycles, so the bench can measure each interval exactly. Codes 6 and above bring the saturated 256 divider within reach. The bus and slow clocks are 10 ns and 30 ns apart in period, which makes every crossing take several bus cycles. That keeps the pending window wide enough to write into deliberately.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 12;

  localparam logic [BUS_W-1:0] KEY_OPEN = 16'h5555;
  localparam logic [BUS_W-1:0] KEY_SHUT = 16'h0000;
  localparam logic [BUS_W-1:0] KEY_FEED = 16'hAAAA;
  localparam logic [BUS_W-1:0] KEY_GO   = 16'hCCCC;

  localparam logic [ADDR_W-1:0] A_KEY = 12'h000;
  localparam logic [ADDR_W-1:0] A_DIV = 12'h004;
  localparam logic [ADDR_W-1:0] A_RLD = 12'h008;
  localparam logic [ADDR_W-1:0] A_STS = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EWC = 12'h014;
  localparam logic [ADDR_W-1:0] A_REV = 12'h3F4;

  // index of each pending bit inside the bus-side pending vector
  localparam int PB_DIV  = 0;
  localparam int PB_RLD  = 1;
  localparam int PB_EWC  = 2;
  localparam int PB_FEED = 3;
  localparam int PB_N    = 4;
endpackage

// File: rtl/wdg_xfer.sv
// Toggle request/acknowledge crossing. The source keeps s_data stable while busy.
module wdg_xfer #(
  parameter int W = 17
) (
  input  logic         s_clk,
  input  logic         d_clk,
  input  logic         rst_n,
  input  logic         s_send,
  input  logic [W-1:0] s_data,
  output logic         s_busy,
  output logic         d_valid,
  output logic [W-1:0] d_data
);
  logic req_t, ack_m, ack_s;
  logic req_m, req_s, ack_t;
  logic d_take;

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t <= 1'b0;
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ack_t;
      ack_s <= ack_m;
      if (s_send && !s_busy) req_t <= ~req_t;
    end
  end

  assign s_busy = req_t ^ ack_s;
  assign d_take = req_s ^ ack_t;

  always_ff @(posedge d_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m   <= 1'b0;
      req_s   <= 1'b0;
      ack_t   <= 1'b0;
      d_valid <= 1'b0;
      d_data  <= '0;
    end else begin
      req_m   <= req_t;
      req_s   <= req_m;
      ack_t   <= req_s;
      d_valid <= d_take;
      if (d_take) d_data <= s_data;
    end
  end

  // R4: payload must not move while the crossing is in flight
  a_r4_payload_stable: assert property (@(posedge s_clk) disable iff (!rst_n)
    s_busy |-> $stable(s_data));
  // R4: each request yields a single delivery strobe
  a_r4_valid_single: assert property (@(posedge d_clk) disable iff (!rst_n)
    d_valid |=> !d_valid);
endmodule

// File: rtl/wdg_regs.sv
// Bus-side register file, key decoder, write guard and pending tracker.
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int          CNT_W = 12,
  parameter int          DIV_W = 4,
  parameter logic [7:0]  REV   = 8'h31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  output logic [BUS_W-1:0]       rdata,
  input  logic                   xfer_busy,
  input  logic                   run_raw,
  output logic                   xfer_go,
  output logic [DIV_W+CNT_W:0]   xfer_pkt,
  output logic                   start_lvl
);
  logic              unlocked;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  rld_q;
  logic              ew_en;
  logic [CNT_W-1:0]  ew_cmp;
  logic [PB_N-1:0]   pend, inflight, set_v;
  logic              on_q, done;
  logic              run_m, running;

  logic wr_key, wr_div, wr_rld, wr_ewc, feed_req;

  assign wr_key   = wr_en && (addr == A_KEY);
  assign wr_div   = wr_en && (addr == A_DIV) && unlocked && !pend[PB_DIV];
  assign wr_rld   = wr_en && (addr == A_RLD) && unlocked && !pend[PB_RLD];
  assign wr_ewc   = wr_en && (addr == A_EWC) && unlocked && !pend[PB_EWC];
  assign feed_req = wr_key && (wdata == KEY_FEED) && !pend[PB_FEED];

  always_comb begin
    set_v          = '0;
    set_v[PB_DIV]  = wr_div;
    set_v[PB_RLD]  = wr_rld;
    set_v[PB_EWC]  = wr_ewc;
    set_v[PB_FEED] = feed_req;
  end

  assign done = on_q && !xfer_go && !xfer_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      start_lvl <= 1'b0;
      div_q     <= '0;
      rld_q     <= '1;
      ew_en     <= 1'b0;
      ew_cmp    <= '0;
      pend      <= '0;
      inflight  <= '0;
      on_q      <= 1'b0;
      xfer_go   <= 1'b0;
      xfer_pkt  <= '0;
      run_m     <= 1'b0;
      running   <= 1'b0;
    end else begin
      run_m   <= run_raw;
      running <= run_m;
      if (wr_key) begin
        case (wdata)
          KEY_OPEN: unlocked  <= 1'b1;
          KEY_SHUT: unlocked  <= 1'b0;
          KEY_GO:   start_lvl <= 1'b1;
          default:  ;
        endcase
      end
      if (wr_div) div_q <= wdata[DIV_W-1:0];
      if (wr_rld) rld_q <= wdata[CNT_W-1:0];
      if (wr_ewc) begin
        ew_en  <= wdata[15];
        ew_cmp <= wdata[CNT_W-1:0];
      end
      xfer_go <= 1'b0;
      if (done) on_q <= 1'b0;
      pend <= (pend & ~(done ? inflight : '0)) | set_v;
      if (!on_q && (|pend)) begin
        xfer_go  <= 1'b1;
        on_q     <= 1'b1;
        inflight <= pend;
        xfer_pkt <= {pend[PB_FEED], div_q, rld_q};
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIV: rdata[DIV_W-1:0] = div_q;
      A_RLD: rdata[CNT_W-1:0] = rld_q;
      A_STS: begin
        rdata[0] = pend[PB_DIV];
        rdata[1] = pend[PB_RLD];
        rdata[3] = pend[PB_EWC];
        rdata[8] = running;
      end
      A_EWC: begin
        rdata[15]        = ew_en;
        rdata[CNT_W-1:0] = ew_cmp;
      end
      A_REV: rdata[7:0] = REV;
      default: rdata = '0;
    endcase
  end

  a_r2_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(div_q));
  a_r5_rld_held_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend[PB_RLD] |=> $stable(rld_q));
  a_r6_running_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(running));
  a_r4_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);
endmodule

// File: rtl/wdg_count.sv
// Slow-domain prescaler and down-counter.
module wdg_count #(
  parameter int CNT_W = 12,
  parameter int DIV_W = 4,
  parameter int PRE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_lvl,
  input  logic                 cfg_valid,
  input  logic [DIV_W+CNT_W:0] cfg_data,
  output logic                 run_s,
  output logic                 rst_req
);
  localparam int PKT_W = DIV_W + CNT_W + 1;

  logic             run_m, run_d;
  logic [DIV_W-1:0] div_s;
  logic [CNT_W-1:0] rld_s, cnt;
  logic [PRE_W-1:0] pre, div_m1;
  logic             pkt_feed;
  logic [CNT_W-1:0] pkt_rld;
  int               sh;

  assign pkt_feed = cfg_data[PKT_W-1];
  assign pkt_rld  = cfg_data[CNT_W-1:0];

  always_comb begin
    sh = int'(div_s) + 2;
    if (sh > PRE_W) sh = PRE_W;
    div_m1 = PRE_W'((1 << sh) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_m   <= 1'b0;
      run_s   <= 1'b0;
      run_d   <= 1'b0;
      div_s   <= '0;
      rld_s   <= '1;
      cnt     <= '1;
      pre     <= '0;
      rst_req <= 1'b0;
    end else begin
      run_m   <= start_lvl;
      run_s   <= run_m;
      run_d   <= run_s;
      rst_req <= 1'b0;
      if (cfg_valid) begin
        div_s <= cfg_data[CNT_W +: DIV_W];
        rld_s <= pkt_rld;
      end
      if (run_s && !run_d) begin
        cnt <= rld_s;
        pre <= '0;
      end else if (cfg_valid && pkt_feed) begin
        cnt <= pkt_rld;
        pre <= '0;
      end else if (run_s) begin
        if (pre >= div_m1) begin
          pre <= '0;
          if (cnt == '0) begin
            cnt     <= rld_s;
            rst_req <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r9_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> run_d);
  a_r6_run_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(run_s));
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int         CNT_W = 12,
  parameter int         DIV_W = 4,
  parameter int         PRE_W = 8,
  parameter logic [7:0] REV   = 8'h31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              wdog_rst_req
);
  localparam int PKT_W = DIV_W + CNT_W + 1;

  logic             x_go, x_busy, x_valid, start_lvl, run_s;
  logic [PKT_W-1:0] x_pkt, x_data;

  wdg_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .REV(REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .xfer_busy(x_busy), .run_raw(run_s), .xfer_go(x_go),
    .xfer_pkt(x_pkt), .start_lvl(start_lvl));

  wdg_xfer #(.W(PKT_W)) u_xfer (
    .s_clk(clk), .d_clk(slow_clk), .rst_n(rst_n), .s_send(x_go),
    .s_data(x_pkt), .s_busy(x_busy), .d_valid(x_valid), .d_data(x_data));

  wdg_count #(.CNT_W(CNT_W), .DIV_W(DIV_W), .PRE_W(PRE_W)) u_count (
    .clk(slow_clk), .rst_n(rst_n), .start_lvl(start_lvl),
    .cfg_valid(x_valid), .cfg_data(x_data), .run_s(run_s),
    .rst_req(wdog_rst_req));
endmodule

// File: tb/wdg_keyed_tb.sv
module wdg_keyed_tb;
  import wdg_pkg::*;
  localparam int CLK_NS  = 10;
  localparam int SLOW_NS = 30;

  logic clk = 0, slow_clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = 0;
  logic [15:0] wdata = 0;
  wire  [15:0] rdata;
  wire         wdog_rst_req;

  wdg_keyed u_dut (.clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdog_rst_req(wdog_rst_req));

  always #(CLK_NS/2) clk = ~clk;
  always #(SLOW_NS/2) slow_clk = ~slow_clk;

  int n_chk = 0, n_bad = 0;
  int slow_cyc = 0, pulses = 0, t_prev = 0, t_last = 0;
  bit wide = 0, prev_req = 0;

  always @(negedge slow_clk) begin
    slow_cyc++;
    if (wdog_rst_req) begin
      if (prev_req) wide = 1;
      t_prev = t_last;
      t_last = slow_cyc;
      pulses++;
    end
    prev_req = wdog_rst_req;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [15:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(A_STS, v);
      if ((v & 16'h000F) == 0) break;
    end
    chk(tag, int'(v & 16'h000F), 0);
  endtask

  function automatic int exp_iv(int rld, int code);
    int s = code + 2;
    if (s > 8) s = 8;
    return (rld + 1) << s;
  endfunction

  task automatic measure(string tag, int rld, int code);
    int base = pulses;
    wait (pulses >= base + 3);
    chk(tag, t_last - t_prev, exp_iv(rld, code));
  endtask

  task automatic config_run(int rld, int code);
    wr(A_KEY, KEY_OPEN);
    wr(A_DIV, 16'(code));
    wr(A_RLD, 16'(rld));
    wait_idle("R4 settle");
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_DIV, v); chk("R1 div", v, 0);
    rd(A_RLD, v); chk("R1 rld", v, 16'h0FFF);
    rd(A_STS, v); chk("R1 sts", v, 0);
    rd(A_EWC, v); chk("R1 ewc", v, 0);
    rd(A_REV, v); chk("R1 rev", v & 16'hFF, 16'h31);
    chk("R1 req", wdog_rst_req, 0);
    // R2 closed writes ignored
    wr(A_DIV, 16'h3); wr(A_RLD, 16'h5);
    rd(A_DIV, v); chk("R2 div locked", v, 0);
    rd(A_RLD, v); chk("R2 rld locked", v, 16'h0FFF);
    rd(A_STS, v); chk("R2 no pending", v, 0);
    // R3 bad key while open keeps it open
    wr(A_KEY, KEY_OPEN);
    wr(A_KEY, 16'h1234);
    wr(A_RLD, 16'h7);
    rd(A_STS, v); chk("R4 rld pending", v & 16'h000F, 16'h2);
    wr(A_RLD, 16'h9);  // R5 rejected while pending
    wait_idle("R4 rld clears");
    rd(A_RLD, v); chk("R3 open kept / R5 first kept", v, 7);
    // R10 early-wake register
    wr(A_EWC, 16'hC0A5);
    rd(A_STS, v); chk("R4 ewc pending bit3", v & 16'h000F, 16'h8);
    wait_idle("R4 ewc clears");
    rd(A_EWC, v); chk("R10 ewc readback", v, 16'h80A5);
    // R2 close, R3 bad key does not open
    wr(A_KEY, KEY_SHUT);
    wr(A_RLD, 16'h2);
    rd(A_RLD, v); chk("R2 closed again", v, 7);
    wr(A_KEY, 16'h5554);
    wr(A_RLD, 16'h3);
    rd(A_RLD, v); chk("R3 bad key stays closed", v, 7);
    // R9 no pulse before start
    repeat (1500) @(negedge clk);
    chk("R9 no req before start", pulses, 0);
    rd(A_STS, v); chk("R9 not running", v, 0);
    // R6 start
    wr(A_KEY, KEY_GO);
    repeat (20) @(negedge clk);
    rd(A_STS, v); chk("R6 running bit8", v, 16'h0100);
    measure("R7 interval rld7 code0", 7, 0);
    // R6 shut key does not stop
    wr(A_KEY, KEY_SHUT);
    base = pulses;
    wait (pulses >= base + 2);
    rd(A_STS, v); chk("R6 still running", v, 16'h0100);
    chk("R6 pulses continue", int'(pulses >= base + 2), 1);
    // R7 random configurations
    for (int i = 0; i < 5; i++) begin
      int rl = $urandom_range(12, 1);
      int cd = $urandom_range(3, 0);
      config_run(rl, cd);
      measure("R7 random interval", rl, cd);
    end
    // R7 smallest reload
    config_run(0, 0);
    measure("R7 reload zero", 0, 0);
    // R11 saturated divider
    config_run(2, 7);
    measure("R11 code7 divides by 256", 2, 7);
    config_run(1, 6);
    measure("R11 code6 divides by 256", 1, 6);
    // R8 feeding holds off the reset request (keys work while closed)
    config_run(30, 2);
    wr(A_KEY, KEY_SHUT);
    base = pulses;
    wait (pulses >= base + 2);
    base = pulses;
    for (int i = 0; i < 25; i++) begin
      wr(A_KEY, KEY_FEED);
      repeat (200) @(negedge clk);
    end
    chk("R8 feeding blocks req", pulses, base);
    measure("R8 expiry resumes", 30, 2);
    chk("R7 pulse one slow cycle", wide, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule